// File: doc/BRIEF.md
# Dual-Core Peripheral Interrupt Router

This block steers a wide vector of peripheral interrupt lines to two processor cores. Every source owns a small routing register. The two low bits of that register act as a per-core enable mask. A source can reach core 0, core 1, both cores or neither core, and the gating is purely combinational, so no interrupt edge is delayed, dropped or added.

Software reaches the routing registers through a simple 16-bit memory-mapped register port. The same port holds a read-only identity register. It answers with the core number of the bus master making the access, so code running on either core can learn which core it is on before it programs its own routes. After reset every source is routed nowhere, so routing must be set up before any interrupt is delivered, even on a system with only one core.

The register port has no back-pressure. A request is taken in the cycle its valid is high. A read answers exactly one cycle later with a response valid and data. A write produces no response.

Top module: `irq_route_top`

## Requirements
- R1: After synchronous reset every routing register holds zero, every core output is low whatever the source lines do, and every routing register reads back as zero.
- R2: The routing register of source n (0 to 111) sits at byte offset 0x80 + 2*n. Bit 0 is the core 0 enable and bit 1 is the core 1 enable, and a write followed by a read returns the written bits.
- R3: Core output c for source n equals source line n ANDed with enable bit c of source n, in the same cycle the source line changes.
- R4: Writing zero to a routing register blocks that source from both cores.
- R5: A read request gets a response valid with its data exactly one cycle later. A write request gets no response, and no request is ever stalled.
- R6: A read at byte offset 0x4 returns the requesting core number (0 or 1) in bit 0 and zeros above it. A write to that offset changes no routing.
- R7: Bits 15 to 2 of every routing register read as zero, and writing ones to them has no effect on routing.
- R8: Any other offset reads as zero and a write to it changes no routing. This covers offset 0, odd offsets inside the routing window, and offsets at 0x160 and above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 16 | Write data |
| req_master | input | 1 | Number of the core issuing the access |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 16 | Read data |
| src_irq | input | 112 | Peripheral interrupt lines |
| core0_irq | output | 112 | Gated interrupts toward core 0 |
| core1_irq | output | 112 | Gated interrupts toward core 1 |

## Verification
The checker watches several rules on every clock cycle. No core output is ever high while its source line is low. A read always answers one cycle later and a write never answers. Bits 15 to 2 of every response are zero, identity reads echo the requesting core, unmapped reads return zero, and the routing state stays put in any cycle without a write. What only the bench scenarios can show is that data lands in the right source's register and reads back from it. They also show that each enable bit routes to the right core under different line patterns, and that writes to the identity register, to odd offsets and to out-of-window offsets leave every route as it was.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_CORES = 2;
  localparam int MASTER_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  typedef logic [NUM_CORES-1:0] core_mask_t;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int                 NUM_SRC    = 112,
  parameter int                 ADDR_W     = 12,
  parameter int                 IDX_W      = 7,
  parameter logic [ADDR_W-1:0]  ROUTE_BASE = 12'h080,
  parameter logic [ADDR_W-1:0]  ID_ADDR    = 12'h004
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_route,
  output logic              hit_id,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] ROUTE_END = ROUTE_BASE + ADDR_W'(2 * NUM_SRC);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset    = addr - ROUTE_BASE;
    idx       = offset[IDX_W:1];
    hit_route = (addr >= ROUTE_BASE) && (addr < ROUTE_END) && !addr[0];
    hit_id    = (addr == ID_ADDR);
  end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 112,
  parameter int IDX_W   = 7
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  core_mask_t                       wr_mask,
  output logic [NUM_SRC-1:0][NUM_CORES-1:0] route_en
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        route_en[n] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(n))) begin
        route_en[n] <= wr_mask;
      end
    end
  end
endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 112
) (
  input  logic [NUM_SRC-1:0]                src_irq,
  input  logic [NUM_SRC-1:0][NUM_CORES-1:0] route_en,
  output logic [NUM_CORES-1:0][NUM_SRC-1:0] core_irq
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      assign core_irq[c][n] = src_irq[n] & route_en[n][c];
    end
  end
endmodule

// File: rtl/irq_route_readback.sv
module irq_route_readback
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 112,
  parameter int IDX_W   = 7,
  parameter int DATA_W  = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic                             hit_route,
  input  logic                             hit_id,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [MASTER_W-1:0]              master,
  input  logic [NUM_SRC-1:0][NUM_CORES-1:0] route_en,
  output logic                             rsp_valid,
  output logic [DATA_W-1:0]                rsp_rdata
);
  core_mask_t        sel_mask;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    sel_mask = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (idx == IDX_W'(n)) sel_mask = route_en[n];
    end
    if (hit_route)   rd_next = DATA_W'(sel_mask);
    else if (hit_id) rd_next = DATA_W'(master);
    else             rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_next : '0;
    end
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 112,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [MASTER_W-1:0] req_master,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [NUM_SRC-1:0]  src_irq,
  output logic [NUM_SRC-1:0]  core0_irq,
  output logic [NUM_SRC-1:0]  core1_irq
);
  localparam int                IDX_W      = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] ROUTE_BASE = ADDR_W'(12'h080);
  localparam logic [ADDR_W-1:0] ID_ADDR    = ADDR_W'(12'h004);

  logic                              hit_route;
  logic                              hit_id;
  logic [IDX_W-1:0]                  idx;
  logic [NUM_SRC-1:0][NUM_CORES-1:0] route_en;
  logic [NUM_CORES-1:0][NUM_SRC-1:0] core_irq;

  irq_route_decode #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .ROUTE_BASE(ROUTE_BASE), .ID_ADDR(ID_ADDR)
  ) u_decode (
    .addr(req_addr), .hit_route(hit_route), .hit_id(hit_id), .idx(idx)
  );

  irq_route_regfile #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regfile (
    .clk(clk), .rst(rst),
    .wr_en(req_valid && req_write && hit_route),
    .wr_idx(idx),
    .wr_mask(req_wdata[NUM_CORES-1:0]),
    .route_en(route_en)
  );

  irq_route_readback #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_readback (
    .clk(clk), .rst(rst),
    .rd_en(req_valid && !req_write),
    .hit_route(hit_route), .hit_id(hit_id), .idx(idx),
    .master(req_master), .route_en(route_en),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  irq_route_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .src_irq(src_irq), .route_en(route_en), .core_irq(core_irq)
  );

  assign core0_irq = core_irq[0];
  assign core1_irq = core_irq[1];
endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 112,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [MASTER_W-1:0]               req_master,
  input  logic                              rsp_valid,
  input  logic [DATA_W-1:0]                 rsp_rdata,
  input  logic [NUM_SRC-1:0]                src_irq,
  input  logic [NUM_SRC-1:0]                core0_irq,
  input  logic [NUM_SRC-1:0]                core1_irq,
  input  logic [NUM_SRC-1:0][NUM_CORES-1:0] route_en
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(12'h080);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(12'h080) + ADDR_W'(2 * NUM_SRC);
  localparam logic [ADDR_W-1:0] ID = ADDR_W'(12'h004);

  logic rd_req, is_id, is_route;
  assign rd_req   = req_valid && !req_write;
  assign is_id    = (req_addr == ID);
  assign is_route = (req_addr >= LO) && (req_addr < HI) && (req_addr[0] == 1'b0);

  // R1: the cycle after reset every output is low
  a_r1_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> (core0_irq == '0) && (core1_irq == '0));

  // R3: a core output never rises without its source line
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    ((core0_irq & ~src_irq) == '0) && ((core1_irq & ~src_irq) == '0));

  // R5: reads answer after one cycle, writes never answer
  a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);
  a_r5_no_extra_rsp: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);

  // R6: identity read echoes the requesting core
  a_r6_identity: assert property (@(posedge clk) disable iff (rst)
    rd_req && is_id |=> rsp_rdata == DATA_W'($past(req_master)));

  // R7: upper bits of every response are zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_rdata[DATA_W-1:NUM_CORES] == '0);

  // R8: unmapped reads give zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    rd_req && !is_id && !is_route |=> rsp_rdata == '0);

  // R8: routing state only changes after a write
  a_r8_state_hold: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(route_en));
endmodule

bind irq_route_top irq_route_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_master(req_master), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .src_irq(src_irq), .core0_irq(core0_irq),
  .core1_irq(core1_irq), .route_en(route_en)
);

// File: tb/test_irq_route_top.sv
module test_irq_route_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 112;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [0:0]    req_master = '0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [NS-1:0] src_irq = '0;
  logic [NS-1:0] core0_irq;
  logic [NS-1:0] core1_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [1:0]  model [NS];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_top i_irq_route_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_master(req_master),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .src_irq(src_irq),
    .core0_irq(core0_irq), .core1_irq(core1_irq)
  );

  function automatic logic [11:0] route_addr(int n);
    return 12'(12'h080 + 2 * n);
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected responses as the design returns them
  always @(negedge clk) begin
    if (!rst && !done && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected response", 128'(rsp_valid), 128'(0));
      end else begin
        check(tag_q.pop_front(), 128'(rsp_rdata), 128'(exp_q.pop_front()));
      end
    end
  end

  task automatic bus_write(logic [11:0] a, logic [15:0] d, logic [0:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_master = m;
    if (a >= 12'h080 && a < 12'h160 && !a[0]) model[(a - 12'h080) >> 1] = d[1:0];
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, logic [0:0] m, string tag);
    logic [15:0] e;
    if (a >= 12'h080 && a < 12'h160 && !a[0]) e = 16'(model[(a - 12'h080) >> 1]);
    else if (a == 12'h004)                    e = 16'(m);
    else                                      e = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_master = m;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_gate(logic [NS-1:0] pat, string tag);
    logic [NS-1:0] e0, e1;
    src_irq = pat;
    #1;
    for (int n = 0; n < NS; n++) begin
      e0[n] = pat[n] & model[n][0];
      e1[n] = pat[n] & model[n][1];
    end
    check({tag, " core0"}, 128'(core0_irq), 128'(e0));
    check({tag, " core1"}, 128'(core1_irq), 128'(e1));
  endtask

  initial begin
    for (int n = 0; n < NS; n++) model[n] = 2'b00;
    src_irq = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_gate('1, "R1 reset");
    bus_read(route_addr(0), 1'b0, "R1 reg0 after reset");
    bus_read(route_addr(111), 1'b0, "R1 reg111 after reset");

    // R2: placement and bit meaning
    bus_write(route_addr(0), 16'h0001, 1'b0);
    bus_write(route_addr(1), 16'h0002, 1'b0);
    bus_write(route_addr(111), 16'h0003, 1'b1);
    bus_write(route_addr(50), 16'h0003, 1'b0);
    bus_read(route_addr(0), 1'b0, "R2 reg0");
    bus_read(route_addr(1), 1'b0, "R2 reg1");
    bus_read(route_addr(111), 1'b1, "R2 reg111");
    // R3: gating under several patterns
    check_gate('1, "R3 all ones");
    check_gate({56{2'b10}}, "R3 alternating");
    check_gate(NS'(1) << 111, "R3 top source");
    // R4: zero blocks both cores
    bus_write(route_addr(50), 16'h0000, 1'b0);
    check_gate('1, "R4 source 50 blocked");
    bus_read(route_addr(50), 1'b0, "R4 reg50");

    // R7: upper bits
    bus_write(route_addr(5), 16'hFFFC, 1'b0);
    bus_read(route_addr(5), 1'b0, "R7 upper-only write");
    bus_write(route_addr(6), 16'hFFFF, 1'b0);
    bus_read(route_addr(6), 1'b0, "R7 all-ones write");

    // R6: identity register
    bus_read(12'h004, 1'b0, "R6 identity core0");
    bus_read(12'h004, 1'b1, "R6 identity core1");
    bus_write(12'h004, 16'hFFFF, 1'b1);
    check_gate('1, "R6 identity write");

    // R8: unmapped offsets
    bus_read(12'h000, 1'b0, "R8 offset 0");
    bus_read(12'h081, 1'b0, "R8 odd offset");
    bus_read(12'h160, 1'b0, "R8 past window");
    bus_read(12'hFFE, 1'b1, "R8 top offset");
    bus_write(12'h081, 16'h0003, 1'b0);
    bus_write(12'h083, 16'h0003, 1'b0);
    bus_write(12'h160, 16'h0003, 1'b0);
    bus_write(12'h000, 16'h0003, 1'b0);
    check_gate('1, "R8 unmapped writes");
    bus_read(route_addr(0), 1'b0, "R8 reg0 after odd write");

    // R2: sweep of every source, then R5 back-to-back reads
    for (int n = 0; n < NS; n++) bus_write(route_addr(n), 16'((n % 3) + 1), n[0]);
    check_gate('1, "R3 sweep");
    @(negedge clk);
    for (int n = 0; n < NS; n++) begin
      exp_q.push_back(16'(model[n])); tag_q.push_back("R5 back-to-back read");
      req_valid = 1'b1; req_write = 1'b0; req_addr = route_addr(n);
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 pending responses", 128'(exp_q.size()), 128'(0));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule